// File: doc/BRIEF.md
# Gated Column Pulse Scheduler

This block sequences column-select pulses across an array of columns during programming. A single active token walks from column 0 to the last column, moving one column per clock. Each column carries a disable bit. The whole disable vector is copied into a holding register when a capture strobe arrives, at the start of a retraining pass. In retraining mode, a column whose held bit is set never raises its select line, while its slot in the sweep still passes by. In execution mode every column raises its select line in turn, whatever the held bits say.

A run enable decides whether a sweep begins from idle, and whether a new sweep starts straight after the previous one ends. A one-cycle end-of-sweep flag marks the cycle after the token has left the last column. All pins are plain control and status signals. No data stream passes through the block, so it has no handshake.

Top module: `gated_col_scheduler`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `col_sel` and `sweep_done` are all zero and every held disable bit is cleared. As a result, a retraining sweep run before any capture passes every column.
- R2: When the token is idle and `run_en` is 1 at a rising edge, the token is placed at column 0 (bit 0 of `col_sel`) after that edge.
- R3: A token at column c < NUM_COLS-1 moves to column c+1 at the next edge, whatever `run_en` is.
- R4: At most one bit of `col_sel` is 1 in any cycle.
- R5: At a rising edge where `gate_cap` is 1, `gate_dis` is copied into the held disable bits.
- R6: With `exec_mode` at 0, a column whose held disable bit is 1 keeps its `col_sel` bit at 0 while the token is on it.
- R7: With `exec_mode` at 0, a column whose held disable bit is 0 drives its `col_sel` bit to 1 while the token is on it.
- R8: With `exec_mode` at 1, the column holding the token drives its `col_sel` bit to 1, whatever its held disable bit is.
- R9: At the edge where the token leaves column NUM_COLS-1, `sweep_done` goes to 1 for exactly one cycle. At that same edge the token restarts at column 0 if `run_en` is 1, and becomes idle otherwise.
- R10: A change of `gate_dis` while `gate_cap` is 0 leaves the held bits unchanged, so the masking seen on `col_sel` is the same as before the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_cap | input | 1 | Capture strobe that copies `gate_dis` into the held bits |
| gate_dis | input | NUM_COLS | Per-column disable bits (1 = column skipped in retraining) |
| exec_mode | input | 1 | 1 = execution mode, all columns pass; 0 = retraining mode |
| run_en | input | 1 | Allows a sweep to start from idle or to restart after the last column |
| col_sel | output | NUM_COLS | Column select lines, at most one high |
| sweep_done | output | 1 | One-cycle pulse after the token leaves the last column |

## Verification
On every cycle the assertions check the following: the select lines stay one-hot or zero, the token shifts by exactly one place, the masking and the execution override hold against the held bits, the held bits change only on a capture, and the end-of-sweep flag pulses after the last column. Only the bench scenarios show the rest. These are whether a new sweep starts or the token goes idle as `run_en` changes, the full mapping from every disable pattern to the columns that fire in both modes, the cleared state after a mid-run reset, and the fact that a `gate_dis` change after capture has no visible effect.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic {
    MODE_RETRAIN = 1'b0,
    MODE_EXEC    = 1'b1
  } gcs_mode_e;
endpackage

// File: rtl/gcs_token_ring.sv
module gcs_token_ring #(
  parameter int NUM_COLS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  output logic [NUM_COLS-1:0] tok_q,
  output logic                sweep_done
);
  localparam logic [NUM_COLS-1:0] HEAD = NUM_COLS'(1);
  localparam int LAST = NUM_COLS - 1;

  logic [NUM_COLS-1:0] tok_d;
  logic idle;
  logic at_end;

  always_comb begin
    idle   = (tok_q == '0);
    at_end = tok_q[LAST];
    if (idle || at_end) begin
      tok_d = run_en ? HEAD : '0;
    end else begin
      tok_d = {tok_q[LAST-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q      <= '0;
      sweep_done <= 1'b0;
    end else begin
      tok_q      <= tok_d;
      sweep_done <= at_end;
    end
  end
endmodule

// File: rtl/gcs_gate_latch.sv
module gcs_gate_latch #(
  parameter int NUM_COLS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate_cap,
  input  logic [NUM_COLS-1:0] gate_dis,
  output logic [NUM_COLS-1:0] gate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else if (gate_cap) begin
      gate_q <= gate_dis;
    end
  end
endmodule

// File: rtl/gcs_col_mask.sv
module gcs_col_mask
  import gcs_pkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input  gcs_mode_e           mode,
  input  logic [NUM_COLS-1:0] tok,
  input  logic [NUM_COLS-1:0] gate_q,
  output logic [NUM_COLS-1:0] col_sel
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic pass;
    assign pass       = (mode == MODE_EXEC) || !gate_q[c];
    assign col_sel[c] = tok[c] && pass;
  end
endmodule

// File: rtl/gated_col_scheduler.sv
module gated_col_scheduler
  import gcs_pkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate_cap,
  input  logic [NUM_COLS-1:0] gate_dis,
  input  logic                exec_mode,
  input  logic                run_en,
  output logic [NUM_COLS-1:0] col_sel,
  output logic                sweep_done
);
  logic [NUM_COLS-1:0] tok_q;
  logic [NUM_COLS-1:0] gate_q;
  gcs_mode_e           mode;

  assign mode = exec_mode ? MODE_EXEC : MODE_RETRAIN;

  gcs_token_ring #(.NUM_COLS(NUM_COLS)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tok_q      (tok_q),
    .sweep_done (sweep_done)
  );

  gcs_gate_latch #(.NUM_COLS(NUM_COLS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_cap (gate_cap),
    .gate_dis (gate_dis),
    .gate_q   (gate_q)
  );

  gcs_col_mask #(.NUM_COLS(NUM_COLS)) u_mask (
    .mode    (mode),
    .tok     (tok_q),
    .gate_q  (gate_q),
    .col_sel (col_sel)
  );
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker #(
  parameter int NUM_COLS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gate_cap,
  input logic [NUM_COLS-1:0] gate_dis,
  input logic                exec_mode,
  input logic [NUM_COLS-1:0] tok_q,
  input logic [NUM_COLS-1:0] gate_q,
  input logic [NUM_COLS-1:0] col_sel,
  input logic                sweep_done
);
  assert_one_hot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q != '0 && !tok_q[NUM_COLS-1]) |=> (tok_q == ($past(tok_q) << 1)));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_cap |=> (gate_q == $past(gate_dis)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_cap |=> $stable(gate_q));

  assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_mode |-> ((col_sel & gate_q) == '0));

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_mode |-> (col_sel == tok_q));

  assert_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_q[NUM_COLS-1] |=> sweep_done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);
endmodule

bind gated_col_scheduler gcs_checker #(.NUM_COLS(NUM_COLS)) u_gcs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_cap   (gate_cap),
  .gate_dis   (gate_dis),
  .exec_mode  (exec_mode),
  .tok_q      (tok_q),
  .gate_q     (gate_q),
  .col_sel    (col_sel),
  .sweep_done (sweep_done)
);

// File: tb/gated_col_scheduler_bench.sv
module gated_col_scheduler_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gate_cap = 1'b0;
  logic [N-1:0] gate_dis = '0;
  logic         exec_mode = 1'b0;
  logic         run_en = 1'b0;
  logic [N-1:0] col_sel;
  logic         sweep_done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model: token position (-1 = idle), held bits, done flag
  int           m_pos = -1;
  logic [N-1:0] m_gate = '0;
  logic         m_done = 1'b0;

  always #10 clk = ~clk;

  gated_col_scheduler #(.NUM_COLS(N)) u_gated_col_scheduler (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_cap   (gate_cap),
    .gate_dis   (gate_dis),
    .exec_mode  (exec_mode),
    .run_en     (run_en),
    .col_sel    (col_sel),
    .sweep_done (sweep_done)
  );

  task automatic check_val(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_sel();
    if (m_pos < 0) return '0;
    if (exec_mode || !m_gate[m_pos]) return N'(1) << m_pos;
    return '0;
  endfunction

  task automatic compare_outputs();
    string tag;
    if (m_pos < 0)                tag = "R2";
    else if (exec_mode)           tag = "R8";
    else if (m_gate[m_pos])       tag = "R6,R10";
    else                          tag = "R3,R5,R7";
    check_val(tag, {1'b0, col_sel}, {1'b0, exp_sel()});
    check_val("R9", {{N{1'b0}}, sweep_done}, {{N{1'b0}}, m_done});
    check_val("R4", {{N{1'b0}}, ($countones(col_sel) <= 1)}, {{N{1'b0}}, 1'b1});
  endtask

  // one clock: inputs already set; model advances at the edge, compare at negedge
  task automatic step();
    @(posedge clk);
    if (gate_cap) m_gate = gate_dis;
    if (m_pos < 0 || m_pos == N - 1) begin
      m_done = (m_pos == N - 1);
      m_pos  = run_en ? 0 : -1;
    end else begin
      m_done = 1'b0;
      m_pos  = m_pos + 1;
    end
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    gate_cap = 1'b0;
    run_en = 1'b0;
    exec_mode = 1'b0;
    repeat (2) @(negedge clk);
    check_val("R1", {1'b0, col_sel}, '0);
    check_val("R1", {{N{1'b0}}, sweep_done}, '0);
    rst_n = 1'b1;
    m_pos = -1;
    m_gate = '0;
    m_done = 1'b0;
    @(negedge clk);
    check_val("R1", {sweep_done, col_sel}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: cleared held bits let every column pass in retraining mode
    gate_dis = '1;
    run_en = 1'b1;
    for (int k = 0; k < N + 2; k++) step();

    // exhaustive: every disable pattern in both modes
    for (int g = 0; g < (1 << N); g++) begin
      for (int ex = 0; ex < 2; ex++) begin
        exec_mode = ex[0];
        gate_dis = N'(g);
        gate_cap = 1'b1;
        step();
        gate_cap = 1'b0;
        gate_dis = ~N'(g); // R10: must not alter masking
        for (int k = 0; k < 2 * N + 2; k++) step();
        run_en = 1'b0;     // R9: sweep ends, token goes idle
        for (int k = 0; k < N + 2; k++) step();
        run_en = 1'b1;
      end
    end

    // run_en toggling mid sweep (R3: no effect until last column)
    exec_mode = 1'b0;
    for (int k = 0; k < 2; k++) step();
    run_en = 1'b0;
    for (int k = 0; k < N + 1; k++) step();

    // mid-run reset clears everything (R1)
    gate_dis = 4'b0101;
    gate_cap = 1'b1;
    run_en = 1'b1;
    step();
    gate_cap = 1'b0;
    step();
    do_reset();
    run_en = 1'b1;
    for (int k = 0; k < N + 2; k++) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule